// File: doc/BRIEF.md
# Input Port Change Detector

This block watches a small group of general-purpose input pins and tells a processor which of them have changed level since it last looked. Each pin first passes through a synchronizer. A level change in either direction on a pin then sets a sticky change flag for that pin. One status word holds these flags in its upper half. Its lower half shows the present synchronized level of each pin, and those bits are not latched.

A per-pin enable mask decides which changes also set a single summary bit. That bit is meant to feed an interrupt controller further downstream, where any final masking takes place. A read strobe stands for the processor reading the status word. The word is valid on `status_o` during the strobe cycle. At the clock edge that samples the strobe, all change flags and the summary bit are cleared.

No data stream passes through this block. All pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure.

Top module: `pin_change_monitor`

## Requirements
- R1: While reset is low and after it is released, all change flags (`status_o[7:4]`) and `summary_o` read 0.
- R2: When pin k changes level in either direction and then holds its new level, `status_o[4+k]` reads 1 after the third rising clock edge that follows the change. It still reads 0 after the second edge.
- R3: `status_o[k]` (k = 0..3) shows the level of pin k as it stood two rising edges earlier. A read does not change it.
- R4: A change flag, once set, stays set until a read. Further level changes on that pin do not clear it.
- R5: A read strobe that is high at a rising edge clears all four change flags and `summary_o` at that edge. The status word shown during the strobe cycle still holds the flags.
- R6: A change detected on pin k while `chg_en_i[k]` is 1 sets `summary_o` at the same edge that sets the change flag of pin k.
- R7: A change detected on pin k while `chg_en_i[k]` is 0 still sets the change flag of pin k, but it has no effect on `summary_o`.
- R8: A change detected at the same edge as a read is not lost. After that edge its flag is 1, and `summary_o` is 1 if the pin is enabled. Flags that were set earlier are cleared.
- R9: The enable mask acts only at the moment a change is detected. Raising an enable bit for a flag that is already set does not set `summary_o`.
- R10: Changes on several pins in the same cycle set every corresponding flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | 4 | Asynchronous general-purpose input pins |
| rd_strobe_i | input | 1 | Processor read of the status word; clears the flags and the summary bit |
| chg_en_i | input | 4 | Per-pin enable of the summary bit |
| status_o | output | 8 | [7:4] sticky change flags, [3:0] synchronized live levels |
| summary_o | output | 1 | Summary input-change bit |

## Verification
Two events can fall in the same cycle: a newly detected pin change and the clearing read. The bench first sets an older flag on one pin. It then changes a second pin and times the read strobe so that it meets the edge at which the second change is detected. The check passes when the older flag is gone and the new flag and the summary bit are both set. A second collision case raises an enable bit after its flag is already set. The check passes when the summary bit stays low.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  // Default pin count and synchronizer depth used by the monitor.
  parameter int unsigned PCM_PINS_DEF   = 4;
  parameter int unsigned PCM_STAGES_DEF = 2;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int unsigned WIDTH  = pcm_pkg::PCM_PINS_DEF,
  parameter int unsigned STAGES = pcm_pkg::PCM_STAGES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pcm_edge_latch.sv
module pcm_edge_latch #(
  parameter int unsigned WIDTH = pcm_pkg::PCM_PINS_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] edge_o,
  output logic [WIDTH-1:0] flags_o
);
  logic [WIDTH-1:0] level_q;
  logic [WIDTH-1:0] flags_q;
  logic [WIDTH-1:0] keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_i;
  end

  assign edge_o = level_i ^ level_q;
  assign keep   = rd_i ? '0 : flags_q;

  // A new change is OR-ed in after the clear, so it survives a read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= keep | edge_o;
  end

  assign flags_o = flags_q;

  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && edge_o == '0) |=> (flags_q == '0));

  assert_edge_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o != '0) |=> ((flags_q & $past(edge_o)) == $past(edge_o)));
endmodule

// File: rtl/pcm_summary.sv
module pcm_summary #(
  parameter int unsigned WIDTH = pcm_pkg::PCM_PINS_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] edge_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic             rd_i,
  output logic             sum_o
);
  logic sum_q;
  logic hit;

  assign hit = |(edge_i & en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= 1'b0;
    else        sum_q <= (sum_q & ~rd_i) | hit;
  end

  assign sum_o = sum_q;

  assert_enabled_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_i & en_i) != '0) |=> sum_q);

  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (((edge_i & en_i) == '0) && (!sum_q || rd_i)) |=> !sum_q);
endmodule

// File: rtl/pin_change_monitor.sv
module pin_change_monitor #(
  parameter int unsigned NUM_PINS    = pcm_pkg::PCM_PINS_DEF,
  parameter int unsigned SYNC_STAGES = pcm_pkg::PCM_STAGES_DEF,
  localparam int unsigned STAT_W     = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                rd_strobe_i,
  input  logic [NUM_PINS-1:0] chg_en_i,
  output logic [STAT_W-1:0]   status_o,
  output logic                summary_o
);
  logic [NUM_PINS-1:0] live;
  logic [NUM_PINS-1:0] edges;
  logic [NUM_PINS-1:0] flags;

  pcm_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(live)
  );

  pcm_edge_latch #(.WIDTH(NUM_PINS)) u_latch (
    .clk(clk), .rst_n(rst_n), .level_i(live), .rd_i(rd_strobe_i),
    .edge_o(edges), .flags_o(flags)
  );

  pcm_summary #(.WIDTH(NUM_PINS)) u_sum (
    .clk(clk), .rst_n(rst_n), .edge_i(edges), .en_i(chg_en_i),
    .rd_i(rd_strobe_i), .sum_o(summary_o)
  );

  assign status_o = {flags, live};

  // Cycles since reset, saturating, so the live-level check never reaches before reset.
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (status_o[STAT_W-1:NUM_PINS] == '0 && !summary_o));

  generate
    if (SYNC_STAGES == 2) begin : g_live_chk
      assert_live_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (status_o[NUM_PINS-1:0] == $past(pins_i, 2)));
    end
  endgenerate
endmodule

// File: tb/tb_pin_change_monitor.sv
`timescale 1ns/1ps
module tb_pin_change_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins_i = 4'h0;
  logic       rd_strobe_i = 1'b0;
  logic [3:0] chg_en_i = 4'h0;
  logic [7:0] status_o;
  logic       summary_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  pin_change_monitor dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .rd_strobe_i(rd_strobe_i),
    .chg_en_i(chg_en_i), .status_o(status_o), .summary_o(summary_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Read strobe for one cycle; returns the word shown during the strobe.
  task automatic do_read(output logic [7:0] word);
    rd_strobe_i = 1'b1;
    word = status_o;
    step(1);
    rd_strobe_i = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pins_i = 4'h0; chg_en_i = 4'h0; rd_strobe_i = 1'b0;
    step(3);
    check("R1 flags in reset", {4'h0, status_o[7:4]}, 8'h00);
    check("R1 summary in reset", {7'h0, summary_o}, 8'h00);
    rst_n = 1'b1;
    step(4);
    check("R1 after release", {summary_o, status_o[7:4]}, 8'h00);
  endtask

  task automatic t_rise_and_live;
    logic [7:0] w;
    chg_en_i = 4'hF;
    pins_i = 4'h1;
    step(1);
    check("R3 live not yet after one edge", {4'h0, status_o[3:0]}, 8'h00);
    step(1);
    check("R3 live after two edges", {4'h0, status_o[3:0]}, 8'h01);
    check("R2 flag not set after two edges", {4'h0, status_o[7:4]}, 8'h00);
    step(1);
    check("R2 flag after three edges", {4'h0, status_o[7:4]}, 8'h01);
    check("R6 summary with flag", {7'h0, summary_o}, 8'h01);
    do_read(w);
    check("R5 word during read", w, 8'h11);
    check("R5 flags cleared", {4'h0, status_o[7:4]}, 8'h00);
    check("R5 summary cleared", {7'h0, summary_o}, 8'h00);
    check("R3 live kept after read", {4'h0, status_o[3:0]}, 8'h01);
  endtask

  task automatic t_fall_sticky;
    logic [7:0] w;
    pins_i = 4'h0;
    step(3);
    check("R2 falling edge flag", {4'h0, status_o[7:4]}, 8'h01);
    pins_i = 4'h1; step(3); pins_i = 4'h0; step(3);
    check("R4 flag sticky over toggles", {4'h0, status_o[7:4]}, 8'h01);
    do_read(w);
    check("R4 cleared only by read", {4'h0, status_o[7:4]}, 8'h00);
  endtask

  task automatic t_masked;
    logic [7:0] w;
    chg_en_i = 4'hB;
    pins_i = 4'h4;
    step(3);
    check("R7 masked flag set", {4'h0, status_o[7:4]}, 8'h04);
    check("R7 masked no summary", {7'h0, summary_o}, 8'h00);
    chg_en_i = 4'hF;
    step(2);
    check("R9 late enable no summary", {7'h0, summary_o}, 8'h00);
    do_read(w);
    check("R9 read word", w, 8'h44);
  endtask

  task automatic t_collide;
    logic [7:0] w;
    chg_en_i = 4'h2;
    pins_i = 4'h5;
    step(3);
    check("R8 setup older flag", {summary_o, status_o[7:4]}, 8'h01);
    pins_i = 4'h7;
    step(2);
    do_read(w);
    check("R8 read word", w, 8'h17);
    check("R8 new flag kept, old cleared", {4'h0, status_o[7:4]}, 8'h02);
    check("R8 summary from colliding change", {7'h0, summary_o}, 8'h01);
    do_read(w);
  endtask

  task automatic t_multi;
    logic [7:0] w;
    chg_en_i = 4'h0;
    pins_i = 4'hA;
    step(3);
    check("R10 several flags", status_o, 8'hDA);
    check("R7 all masked no summary", {7'h0, summary_o}, 8'h00);
    do_read(w);
    check("R10 all cleared", status_o, 8'h0A);
  endtask

  initial begin
    #500us;
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    step(1);
    t_reset();
    t_rise_and_live();
    t_fall_sticky();
    t_masked();
    t_collide();
    t_multi();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule